// File: doc/BRIEF.md
# PHY Port-Mirror Bring-Up Sequencer

This block switches on the port-mirror flag in a group of gigabit Ethernet PHYs after the system comes out of reset. A single `start` pulse begins a walk over a fixed list of PHY management addresses. For each PHY the block reads one configuration register, sets the mirror flag in the value it read, and writes the result back. All other bits in that register keep the value that was read.

The target register lies above the directly addressable range of the management bus, so the block never builds bus frames itself. Instead it issues commands on a simple request/response port. Each command carries a strobe, a read/write select, the PHY address, the register address and the write data. A separate extended-register access engine serves these commands and answers with read data, a completion pulse or a timeout.

When every PHY has been written, the block pulses `done` for one cycle. An engine timeout ends the walk at once and sets a sticky `error` flag.

Top module: `phy_mirror_init`

## Requirements
- R1: After reset, `cmd_start`, `done` and `error` are 0, and no command is issued until `start` is seen high.
- R2: The PHYs are visited in the order 0x01, 0x03, 0x0C, 0x0F. Every command targets register address 0x0031 with the PHY address of the current entry.
- R3: For each PHY a read command (`cmd_write`=0) is issued first. The matching write (`cmd_write`=1) is issued only after the read's `rsp_done`. `cmd_start` is high for exactly one cycle per command and stays low while a response is awaited.
- R4: The write data equals the read data with bit 0 forced to 1. Bits 15..1 are unchanged.
- R5: `done` goes high for exactly one cycle, in the cycle after the `rsp_done` of the fourth write. The block then issues no further command.
- R6: A `start` pulse that arrives while a walk is in progress has no effect. The walk continues unchanged, and no extra walk follows it.
- R7: An `rsp_timeout` while a response is awaited sets `error` in the next cycle and aborts the walk. No further command is issued and `done` does not pulse.
- R8: `error` stays 1 until reset, including through a later `start`. A later `start` still runs a complete walk and produces `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk when idle |
| done | output | 1 | One-cycle pulse after the last write completes |
| error | output | 1 | Sticky flag, set by an engine timeout |
| cmd_start | output | 1 | One-cycle command strobe to the access engine |
| cmd_write | output | 1 | 1 = write command, 0 = read command |
| cmd_phy | output | 5 | PHY management address |
| cmd_reg | output | 16 | Extended register address |
| cmd_wdata | output | 16 | Data for a write command |
| rsp_rdata | input | 16 | Read data, valid with `rsp_done` |
| rsp_done | input | 1 | Engine completed the current command |
| rsp_timeout | input | 1 | Engine gave up on the current command |

## Verification
The bench targets read values whose bit 0 is already set, as well as all-zero and all-ones-but-bit-0 values. A design that overwrote the register or cleared bits instead of merging would write the wrong data in those cases.

The response latency is random, including zero. This exposes a sequencer that fires the write before the read finishes or re-strobes while waiting.

Timeouts are injected at read and at write positions. These catch a block that carries on, pulses `done`, or drops the error flag on the next `start`. A `start` poked mid-walk reveals a sequencer that restarts from the first PHY or queues a second walk.

// File: rtl/phy_mirror_init.sv
module phy_mirror_init #(
  parameter int PHY_W    = 5,
  parameter int REG_W    = 16,
  parameter int DATA_W   = 16,
  parameter int N_PHY    = 4,
  parameter logic [N_PHY*PHY_W-1:0] PHY_LIST = {5'h0F, 5'h0C, 5'h03, 5'h01},
  parameter logic [REG_W-1:0] TARGET_REG = 16'h0031,
  parameter int FLAG_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              done,
  output logic              error,
  output logic              cmd_start,
  output logic              cmd_write,
  output logic [PHY_W-1:0]  cmd_phy,
  output logic [REG_W-1:0]  cmd_reg,
  output logic [DATA_W-1:0] cmd_wdata,
  input  logic [DATA_W-1:0] rsp_rdata,
  input  logic              rsp_done,
  input  logic              rsp_timeout
);

  localparam int IDX_W = (N_PHY > 1) ? $clog2(N_PHY) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_PHY - 1);
  localparam logic [DATA_W-1:0] FLAG_MASK = DATA_W'(1) << FLAG_BIT;

  typedef enum logic [2:0] {S_IDLE, S_RD_GO, S_RD_WAIT, S_WR_GO, S_WR_WAIT} st_t;

  st_t               state;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] wdata_q;
  logic              done_q, err_q;
  logic              waiting;

  assign waiting   = (state == S_RD_WAIT) || (state == S_WR_WAIT);
  assign cmd_start = (state == S_RD_GO) || (state == S_WR_GO);
  assign cmd_write = (state == S_WR_GO);
  assign cmd_phy   = PHY_LIST[idx*PHY_W +: PHY_W];
  assign cmd_reg   = TARGET_REG;
  assign cmd_wdata = wdata_q;
  assign done      = done_q;
  assign error     = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      idx     <= '0;
      wdata_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          idx   <= '0;
          state <= S_RD_GO;
        end
        S_RD_GO: state <= S_RD_WAIT;
        S_RD_WAIT: begin
          if (rsp_timeout) begin
            err_q <= 1'b1;
            state <= S_IDLE;
          end else if (rsp_done) begin
            wdata_q <= rsp_rdata | FLAG_MASK;
            state   <= S_WR_GO;
          end
        end
        S_WR_GO: state <= S_WR_WAIT;
        S_WR_WAIT: begin
          if (rsp_timeout) begin
            err_q <= 1'b1;
            state <= S_IDLE;
          end else if (rsp_done) begin
            if (idx == LAST_IDX) begin
              done_q <= 1'b1;
              state  <= S_IDLE;
            end else begin
              idx   <= idx + 1'b1;
              state <= S_RD_GO;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> !cmd_start);

  a_r3_quiet_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> !cmd_start);

  a_r3_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RD_WAIT && rsp_done && !rsp_timeout) |=> (cmd_start && cmd_write));

  a_r4_flag_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && cmd_write) |-> cmd_wdata[FLAG_BIT]);

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_abort_on_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && rsp_timeout) |=> (error && !cmd_start && !done));

  a_r8_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> error);

endmodule

// File: tb/phy_mirror_init_test.sv
module phy_mirror_init_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic done, error, cmd_start, cmd_write;
  logic [4:0]  cmd_phy;
  logic [15:0] cmd_reg, cmd_wdata;
  logic [15:0] rsp_rdata = '0;
  logic rsp_done = 1'b0;
  logic rsp_timeout = 1'b0;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  phy_mirror_init uut (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .error(error),
    .cmd_start(cmd_start), .cmd_write(cmd_write), .cmd_phy(cmd_phy),
    .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata), .rsp_rdata(rsp_rdata),
    .rsp_done(rsp_done), .rsp_timeout(rsp_timeout)
  );

  function automatic logic [4:0] exp_phy(input int i);
    case (i)
      0: return 5'h01;
      1: return 5'h03;
      2: return 5'h0C;
      default: return 5'h0F;
    endcase
  endfunction

  function automatic logic [15:0] set_flag(input logic [15:0] v);
    return v | 16'h0001;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic serve(input bit wr, input int pi, input logic [15:0] rdv, input logic [15:0] expw,
                       input int lat, input bit tmo, input bit poke);
    int n = 0;
    while (!cmd_start && n < 50) begin
      @(negedge clk);
      n++;
    end
    check(cmd_start, "R3 strobe seen", 32'(cmd_start), 1);
    check(cmd_write == wr, "R3 command kind", 32'(cmd_write), 32'(wr));
    check(cmd_phy == exp_phy(pi), "R2 phy address", 32'(cmd_phy), 32'(exp_phy(pi)));
    check(cmd_reg == 16'h0031, "R2 register address", 32'(cmd_reg), 32'h31);
    if (wr) check(cmd_wdata == expw, "R4 write data", 32'(cmd_wdata), 32'(expw));
    @(negedge clk);
    for (int k = 0; k < lat; k++) begin
      check(!cmd_start, "R3 quiet while waiting", 32'(cmd_start), 0);
      if (poke && k == 0) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    if (tmo) rsp_timeout = 1'b1;
    else begin
      rsp_done  = 1'b1;
      rsp_rdata = rdv;
    end
    if (poke && lat == 0) start = 1'b1;
    @(negedge clk);
    rsp_done = 1'b0;
    rsp_timeout = 1'b0;
    start = 1'b0;
    rsp_rdata = $urandom;
  endtask

  // tmo_at: access number 0..7 that times out, or -1
  task automatic run_walk(input bit poke, input int tmo_at, input bit err_before, input int fixed_rd);
    logic [15:0] rd;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 4; i++) begin
      rd = (fixed_rd >= 0) ? 16'(fixed_rd) : 16'($urandom);
      if (i == 1 && fixed_rd < 0) rd = rd | 16'h0001;
      serve(1'b0, i, rd, 16'h0, $urandom_range(0, 5), tmo_at == 2*i, poke && i == 1);
      if (tmo_at == 2*i) begin
        check(error, "R7 error after read timeout", 32'(error), 1);
        break;
      end
      check(!done, "R5 no done mid walk", 32'(done), 0);
      serve(1'b1, i, 16'h0, set_flag(rd), $urandom_range(0, 5), tmo_at == 2*i+1, 1'b0);
      if (tmo_at == 2*i+1) begin
        check(error, "R7 error after write timeout", 32'(error), 1);
        break;
      end
      check(done == (i == 3), "R5 done timing", 32'(done), 32'(i == 3));
      if (err_before) check(error, "R8 error held during walk", 32'(error), 1);
    end
    @(negedge clk);
    check(!done, "R5 done lasts one cycle", 32'(done), 0);
    for (int k = 0; k < 12; k++) begin
      check(!cmd_start, "R5 R6 R7 idle after walk", 32'(cmd_start), 0);
      if (tmo_at >= 0) check(!done, "R7 no done after abort", 32'(done), 0);
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'h1234ABCD));
    repeat (3) @(negedge clk);
    check(!cmd_start, "R1 reset strobe", 32'(cmd_start), 0);
    check(!done, "R1 reset done", 32'(done), 0);
    check(!error, "R1 reset error", 32'(error), 0);
    rst_n = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(!cmd_start, "R1 no command without start", 32'(cmd_start), 0);
    end
    run_walk(1'b0, -1, 1'b0, 16'h0000);
    run_walk(1'b0, -1, 1'b0, 16'hFFFE);
    run_walk(1'b0, -1, 1'b0, 16'hFFFF);
    run_walk(1'b1, -1, 1'b0, -1);
    for (int t = 0; t < 6; t++) run_walk(1'b0, -1, 1'b0, -1);
    check(!error, "R7 no error without timeout", 32'(error), 0);
    run_walk(1'b0, 2, 1'b0, -1);
    run_walk(1'b0, -1, 1'b1, -1);
    check(error, "R8 error survives new walk", 32'(error), 1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check(!error, "R8 error cleared by reset", 32'(error), 0);
    run_walk(1'b0, 7, 1'b0, -1);
    run_walk(1'b0, 5, 1'b1, -1);
    check(error, "R8 error still set", 32'(error), 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule